// File: doc/BRIEF.md
# Cycle-Stealing Shared Bus Master

This block sits between a processor core and a system bus that the processor shares with a video controller. The video controller owns the bus in alternate phases and signals this on a grant input: while grant is high the processor may use the bus, and while it is low every processor driver must float. The block accepts one read or write request at a time from the core and times each transfer from the edges of the grant signal, not from the system clock. A ready input may hold a read in place indefinitely. Writes ignore it.

Grant and ready are first passed through a `SYNC_STAGES`-flop synchroniser. Edges of the synchronised grant drive a seven-state machine.

- **IDLE** takes a request. It goes to **RD_SEEK_LOW** for a read and to **WR_SEEK_FALL** for a write.
- A read moves through three states, each left on one grant edge:
  - **RD_SEEK_LOW** waits for a grant fall and then goes to **RD_SEEK_HIGH**.
  - **RD_SEEK_HIGH** waits for a grant rise and then goes to **RD_SEEK_FALL**.
  - **RD_SEEK_FALL** waits for a grant fall and then goes to **RD_ADDR**.
- **RD_ADDR** presents the address. It stays there at each fall that finds ready low. At a fall with ready high it captures data, pulses done and returns to **IDLE**.
- **WR_SEEK_FALL** goes to **WR_DRIVE** at a fall.
- **WR_DRIVE** drives address, write direction and data. It releases them and returns to **IDLE** at the next fall.

Address, direction and data enables are also gated by the raw grant pin. They therefore float in the same cycle that grant drops.

Top module: `phase_bus_master`

## Requirements
- R1: During reset `abus_oe_o`, `dbus_oe_o` and `done_o` are 0 and `rd_data_o` is 0.
- R2: In any cycle where `grant_i` is 0, `abus_oe_o` and `dbus_oe_o` are both 0.
- R3: A read accepted during a grant-high phase is held until it has seen a grant fall, a grant rise and a further fall. Only after that is its address driven with `rw_o`=1 (1 means read). With ready high it completes at the third grant fall counted from acceptance.
- R4: If the synchronised ready is 0 at a grant fall while the read address is being driven, the read does not complete. It keeps the same address driven in the following grant-high phases, and it completes at the first such fall where ready is 1.
- R5: `rd_data_o` is the value present on `dbus_i` in the last clock of the grant-high phase that ends the read.
- R6: A write drives `abus_o`, `rw_o`=0 and `dbus_o` with `dbus_oe_o`=1 in the grant-high phase that follows the first grant fall after acceptance. It completes at the next fall, after which `rw_o` is 1 and `dbus_oe_o` is 0.
- R7: The ready input has no effect on writes: a write made with ready held at 0 completes at the second grant fall, just as one made with ready at 1.
- R8: `done_o` is a single-clock pulse that appears `SYNC_STAGES`+1 clocks after the completing grant fall. `rd_data_o` holds the read result from that pulse onward.
- R9: A request presented while a transfer is outstanding is ignored. It produces no extra done pulse and no bus activity, and the outstanding transfer keeps its address.
- R10: `dbus_oe_o` is never 1 while `rw_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | Bus grant from the video controller, 1 = processor may drive |
| ready_i | input | 1 | Read ready, 0 stalls a read |
| req_valid_i | input | 1 | Core request strobe, accepted only in IDLE |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Request write data |
| abus_o | output | ADDR_W | Address bus value |
| abus_oe_o | output | 1 | Enable for address and direction drivers |
| rw_o | output | 1 | Direction, 1 = read, 0 = write |
| dbus_i | input | DATA_W | Data bus as seen at the pins |
| dbus_o | output | DATA_W | Data bus drive value |
| dbus_oe_o | output | 1 | Data bus output enable |
| rd_data_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions take for granted several things about the inputs:
- Every grant phase lasts longer than `SYNC_STAGES`+2 clocks, so that no synchronised edge is lost.
- Ready is stable for a few clocks around each grant fall.
- The core does not rely on a request made outside IDLE.

The stimulus keeps within these limits. It uses fixed eight-clock grant phases and changes ready only in the middle of a grant-high phase. It issues requests mid-phase, apart from one deliberately ignored request. A memory model answers with the correct byte only in the last high clock and with zero otherwise, so a read that samples early is caught.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SEEK_LOW,
        ST_RD_SEEK_HIGH,
        ST_RD_SEEK_FALL,
        ST_RD_ADDR,
        ST_WR_SEEK_FALL,
        ST_WR_DRIVE
    } pbm_state_e;

endpackage

// File: rtl/pbm_sync.sv
module pbm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_raw,
    input  logic              grant_s,
    input  logic              ready_s,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dbus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              addr_drive,
    output logic              data_drive,
    output logic              rw_read,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    pbm_state_e state, nxt;
    logic              g_prev;
    logic              g_fall, g_rise;
    logic [DATA_W-1:0] shadow;

    // edge detection on the synchronised grant
    always_ff @(posedge clk) begin
        if (!rst_n) g_prev <= 1'b0;
        else        g_prev <= grant_s;
    end
    assign g_fall = g_prev & ~grant_s;
    assign g_rise = ~g_prev & grant_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:         if (req_valid) nxt = req_write ? ST_WR_SEEK_FALL : ST_RD_SEEK_LOW;
            ST_RD_SEEK_LOW:  if (g_fall) nxt = ST_RD_SEEK_HIGH;
            ST_RD_SEEK_HIGH: if (g_rise) nxt = ST_RD_SEEK_FALL;
            ST_RD_SEEK_FALL: if (g_fall) nxt = ST_RD_ADDR;
            ST_RD_ADDR:      if (g_fall && ready_s) nxt = ST_IDLE;
            ST_WR_SEEK_FALL: if (g_fall) nxt = ST_WR_DRIVE;
            ST_WR_DRIVE:     if (g_fall) nxt = ST_IDLE;
            default:         nxt = ST_IDLE;
        endcase
    end

    // drive intents per state
    always_comb begin
        addr_drive = 1'b0;
        data_drive = 1'b0;
        rw_read    = 1'b1;
        unique case (state)
            ST_RD_ADDR:  addr_drive = 1'b1;
            ST_WR_DRIVE: begin
                addr_drive = 1'b1;
                data_drive = 1'b1;
                rw_read    = 1'b0;
            end
            default: ;
        endcase
    end

    // request latch, sampling and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            shadow  <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_RD_ADDR && grant_raw)
                shadow <= dbus_in;
            if (state == ST_RD_ADDR && g_fall && ready_s) begin
                rd_data <= shadow;
                done    <= 1'b1;
            end
            if (state == ST_WR_DRIVE && g_fall)
                done <= 1'b1;
        end
    end

    // R8: completion only follows a detected grant fall
    a_r8_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(g_fall));

    // R4: ready low at a fall keeps the read in its address phase
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ADDR && g_fall && !ready_s) |=> (state == ST_RD_ADDR));

    // R9: latched address never changes while a transfer is outstanding
    a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(addr_q));

endmodule

// File: rtl/phase_bus_master.sv
module phase_bus_master #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    input  logic              ready_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [ADDR_W-1:0] abus_o,
    output logic              abus_oe_o,
    output logic              rw_o,
    input  logic [DATA_W-1:0] dbus_i,
    output logic [DATA_W-1:0] dbus_o,
    output logic              dbus_oe_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);
    logic grant_s, ready_s;
    logic addr_drive, data_drive, rw_read;

    pbm_sync #(.STAGES(SYNC_STAGES)) u_grant_sync (
        .clk(clk), .rst_n(rst_n), .d(grant_i), .q(grant_s)
    );

    pbm_sync #(.STAGES(SYNC_STAGES)) u_ready_sync (
        .clk(clk), .rst_n(rst_n), .d(ready_i), .q(ready_s)
    );

    pbm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_raw  (grant_i),
        .grant_s    (grant_s),
        .ready_s    (ready_s),
        .req_valid  (req_valid_i),
        .req_write  (req_write_i),
        .req_addr   (req_addr_i),
        .req_wdata  (req_wdata_i),
        .dbus_in    (dbus_i),
        .addr_q     (abus_o),
        .wdata_q    (dbus_o),
        .addr_drive (addr_drive),
        .data_drive (data_drive),
        .rw_read    (rw_read),
        .rd_data    (rd_data_o),
        .done       (done_o)
    );

    // the raw pin gates every driver so the bus floats at once
    assign abus_oe_o = grant_i & addr_drive;
    assign dbus_oe_o = grant_i & data_drive;
    assign rw_o      = rw_read;

    // R2: nothing driven while the video side owns the bus
    a_r2_float_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_i |-> (!abus_oe_o && !dbus_oe_o));

    // R10: data drivers only in the write direction
    a_r10_data_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe_o |-> !rw_o);

    // R8: done lasts exactly one clock
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: the driven address stays put across consecutive driven cycles
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (abus_oe_o && $past(abus_oe_o)) |-> $stable(abus_o));

endmodule

// File: tb/tb_phase_bus_master.sv
module tb_phase_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;
    localparam int AW         = 16;
    localparam int DW         = 8;
    localparam int SS         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grant_i = 1'b0;
    logic          ready_i = 1'b1;
    logic          req_valid_i = 1'b0;
    logic          req_write_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic [AW-1:0] abus_o;
    logic          abus_oe_o, rw_o, dbus_oe_o, done_o;
    logic [DW-1:0] dbus_i, dbus_o, rd_data_o;
    logic          late = 1'b0;

    int tests = 0, fails = 0;
    int fall_cnt = 0, done_cnt = 0, since_fall = 0, done_lat = -1;
    int viol_z = 0, viol_addr = 0, viol_rw = 0, rd_drive = 0;
    int wr_seen_cnt = 0, wr_seen_addr = 0, wr_seen_data = 0;
    logic [AW-1:0] exp_addr = '0;
    logic prev_g = 1'b0;
    bit finished = 0;

    phase_bus_master #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .ready_i(ready_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .abus_o(abus_o), .abus_oe_o(abus_oe_o), .rw_o(rw_o),
        .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o),
        .rd_data_o(rd_data_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: correct byte only in the last clock of a grant-high phase
    assign dbus_i = late ? (abus_o[DW-1:0] ^ 8'hA5) : 8'h00;

    // grant generator: PH clocks high, PH clocks low
    initial begin
        @(posedge clk); #1;
        forever begin
            grant_i = 1'b1;
            repeat (PH-1) begin @(posedge clk); #1; end
            late = 1'b1;
            @(posedge clk); #1;
            late = 1'b0;
            grant_i = 1'b0;
            fall_cnt++;
            repeat (PH) begin @(posedge clk); #1; end
        end
    end

    // bus monitor
    always @(negedge clk) begin
        if (!grant_i && prev_g) since_fall = 0;
        else since_fall++;
        prev_g = grant_i;
        if (rst_n) begin
            if (!grant_i && (abus_oe_o || dbus_oe_o)) viol_z++;
            if (abus_oe_o && abus_o != exp_addr) viol_addr++;
            if (dbus_oe_o && rw_o) viol_rw++;
            if (abus_oe_o && rw_o) rd_drive++;
            if (abus_oe_o && dbus_oe_o && !rw_o) begin
                wr_seen_cnt++;
                wr_seen_addr = int'(abus_o);
                wr_seen_data = int'(dbus_o);
            end
            if (done_o) begin
                done_cnt++;
                done_lat = since_fall;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic align_mid_high();
        @(posedge grant_i);
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        req_write_i = w; req_addr_i = a; req_wdata_i = d; req_valid_i = 1'b1;
        @(posedge clk); #1;
        req_valid_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 400) begin @(posedge clk); #1; n++; end
        @(negedge clk); #1;
    endtask

    task automatic test_reset();
        repeat (5) begin @(posedge clk); #1; end
        check(!abus_oe_o, "R1", "abus_oe in reset", abus_oe_o, 0);
        check(!dbus_oe_o, "R1", "dbus_oe in reset", dbus_oe_o, 0);
        check(!done_o, "R1", "done in reset", done_o, 0);
        check(rd_data_o == 0, "R1", "rd_data in reset", rd_data_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_read(logic [AW-1:0] a);
        int f0, d0, r0;
        exp_addr = a;
        align_mid_high();
        f0 = fall_cnt; d0 = done_cnt; r0 = rd_drive;
        issue(1'b0, a, 8'h00);
        wait_done();
        check(fall_cnt - f0 == 3, "R3", "falls until read done", fall_cnt - f0, 3);
        check(rd_drive > r0, "R3", "read address driven", rd_drive - r0, 1);
        check(rd_data_o == (a[DW-1:0] ^ 8'hA5), "R5", "read data", rd_data_o, a[DW-1:0] ^ 8'hA5);
        check(done_lat == SS + 1, "R8", "done latency after fall", done_lat, SS + 1);
        check(done_cnt - d0 == 1, "R8", "done pulses for read", done_cnt - d0, 1);
    endtask

    task automatic test_ready_hold(logic [AW-1:0] a);
        int f0, d0;
        exp_addr = a;
        align_mid_high();
        f0 = fall_cnt; d0 = done_cnt;
        issue(1'b0, a, 8'h00);
        ready_i = 1'b0;
        wait (fall_cnt == f0 + 4);
        check(done_cnt == d0, "R4", "no done while ready low", done_cnt - d0, 0);
        align_mid_high();
        ready_i = 1'b1;
        wait_done();
        check(fall_cnt - f0 == 5, "R4", "falls with two stalls", fall_cnt - f0, 5);
        check(rd_data_o == (a[DW-1:0] ^ 8'hA5), "R4", "stalled read data", rd_data_o, a[DW-1:0] ^ 8'hA5);
        check(viol_addr == 0, "R4", "address held during stall", viol_addr, 0);
    endtask

    task automatic test_write(logic [AW-1:0] a, logic [DW-1:0] d, bit rdy, string req);
        int f0, d0, w0;
        exp_addr = a;
        ready_i = rdy;
        align_mid_high();
        f0 = fall_cnt; d0 = done_cnt; w0 = wr_seen_cnt;
        issue(1'b1, a, d);
        wait_done();
        check(fall_cnt - f0 == 2, req, "falls until write done", fall_cnt - f0, 2);
        check(wr_seen_cnt > w0, req, "write drive cycles", wr_seen_cnt - w0, 1);
        check(wr_seen_addr == int'(a), "R6", "written address", wr_seen_addr, int'(a));
        check(wr_seen_data == int'(d), "R6", "written data", wr_seen_data, int'(d));
        check(rw_o == 1'b1, "R6", "rw back to read", rw_o, 1);
        check(!dbus_oe_o, "R6", "data released", dbus_oe_o, 0);
        check(done_cnt - d0 == 1, "R8", "done pulses for write", done_cnt - d0, 1);
        ready_i = 1'b1;
    endtask

    task automatic test_ignore(logic [AW-1:0] a, logic [AW-1:0] b);
        int d0, w0;
        exp_addr = a;
        align_mid_high();
        d0 = done_cnt; w0 = wr_seen_cnt;
        issue(1'b0, a, 8'h00);
        repeat (2) begin @(posedge clk); #1; end
        issue(1'b1, b, 8'h77);
        wait_done();
        repeat (4 * PH) begin @(posedge clk); #1; end
        check(done_cnt - d0 == 1, "R9", "single done for ignored request", done_cnt - d0, 1);
        check(wr_seen_cnt == w0, "R9", "no write from ignored request", wr_seen_cnt - w0, 0);
        check(viol_addr == 0, "R9", "outstanding address kept", viol_addr, 0);
        check(rd_data_o == (a[DW-1:0] ^ 8'hA5), "R9", "original read result", rd_data_o, a[DW-1:0] ^ 8'hA5);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_read(16'h1234);
        test_read(16'hFF01);
        test_ready_hold(16'h0C3E);
        test_write(16'hABCD, 8'h3C, 1'b1, "R6");
        test_write(16'h0042, 8'hC9, 1'b0, "R7");
        test_ignore(16'h2468, 16'h1357);
        test_read(16'h00F0);
        check(viol_z == 0, "R2", "drive cycles with grant low", viol_z, 0);
        check(viol_rw == 0, "R10", "data drive in read direction", viol_rw, 0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 completion");
        finish_run();
    end
endmodule